// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a small byte-wide nonvolatile memory, with a plain synchronous RAM standing in for the storage array. A host selects it by pulling the chip-select input low. It then clocks in an 8-bit command, any address bytes and any data bytes, using SPI mode 0 or mode 3. The block runs on its own system clock. It samples the SPI pins through a two-stage synchroniser and finds the SCK and chip-select edges in that clock domain. The serial clock's half period therefore has to be at least five system clocks.

Six commands are decoded: set write enable, clear write enable, read status, write status, read array and write array. Array writes are first collected in a page buffer. The data reaches the RAM only when chip select rises at the end of a complete and permitted write sequence. At that point a self-timed write cycle begins, modelled as a busy counter of `WRITE_CYCLES` clocks. A status write also starts this cycle. During the cycle only the status read is served.

Writes are gated by three things: the write-enable latch, two block-protect bits that cover part or all of the array, and a write-protect pin. The write-protect pin acts on status writes only when a lock bit in the status register is set. The serial output carries a separate enable, so that the chip level can tri-state the pin.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and `so_en` is low.
- R2: Command 0x05 returns the status byte MSB first. Bit 7 is the lock bit, bit 6 reads 0, bits 5:4 are two spare setting bits, bits 3:2 are the block-protect field, bit 1 is the write-enable latch and bit 0 is the busy flag. The byte is repeated for as long as SCK keeps running.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. Each takes effect at the chip-select rise after exactly one whole byte.
- R4: Command 0000_A011 reads and command 0000_A010 writes. Bit 3 of the command is address bit 8, and one address byte follows. A read streams bytes from incrementing addresses and wraps from the last address to 0. Written data appears in the array only after the chip-select rise.
- R5: Write data bytes beyond the end of a `PAGE_BYTES` page wrap to the start of the same page.
- R6: An array write or a status write issued while the write-enable latch is 0 changes nothing and does not start a write cycle.
- R7: An accepted write keeps the busy flag at 1 for `WRITE_CYCLES` clocks. While busy, every command except the status read is ignored, so no read data is driven. The write-enable latch is 0 when the cycle ends.
- R8: The block-protect field 00 protects nothing, 01 protects the top quarter, 10 protects the top half and 11 protects the whole array. A write to a protected page is discarded.
- R9: When the lock bit is 1 and `wp_n` is low at any time while chip select is low, a status write is dropped. When the lock bit is 0, `wp_n` has no effect.
- R10: Driving `wp_n` low after a status write cycle has started does not change the result of that write.
- R11: A transaction that ends with a partly received byte is discarded.
- R12: `so_en` is high only while chip select is low and read data is being shifted out. `so` changes on SCK falling edges.
- R13: Mode 3 (SCK idling high) behaves the same as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, sampled on SCK rise |
| wp_n | input | 1 | Hardware write protect, active low |
| so | output | 1 | Serial data out, updated on SCK fall |
| so_en | output | 1 | Output enable for the serial data pin |

## Verification
Each pin passes through two synchroniser flops and one edge-compare stage. A new `so` bit is therefore registered three clocks after the host drops SCK. The first byte of read data is fetched from the RAM about four clocks after the SCK rise that completes the address. The bench keeps every SCK half period at six clocks and samples `so` just before it raises SCK, so every sample lands after the bit is due. Commit results (status bits, the latch and the start of the busy flag) settle three clocks after chip select rises. The bench waits twelve clocks before its next transaction, then polls the status byte until the busy flag clears, rather than counting cycles, and checks the array only after that.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WEN_SET, CMD_WEN_CLR, CMD_STAT_RD,
    CMD_STAT_WR, CMD_ARR_RD, CMD_ARR_WR
  } cmd_e;

  // Decode one command byte; hi_addr_ok allows bit 3 to carry an address bit
  function automatic cmd_e decode_cmd(input logic [7:0] b, input logic hi_addr_ok);
    cmd_e c;
    c = CMD_NONE;
    if (b == 8'h06)      c = CMD_WEN_SET;
    else if (b == 8'h04) c = CMD_WEN_CLR;
    else if (b == 8'h05) c = CMD_STAT_RD;
    else if (b == 8'h01) c = CMD_STAT_WR;
    else if (b[7:4] == 4'h0 && (hi_addr_ok || !b[3])) begin
      if (b[2:0] == 3'b011)      c = CMD_ARR_RD;
      else if (b[2:0] == 3'b010) c = CMD_ARR_WR;
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic si_s,
  output logic wp_low
);
  logic [2:0] sck_q, cs_q;
  logic [1:0] si_q, wp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
      wp_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      si_q  <= {si_q[0], si};
      wp_q  <= {wp_q[0], wp_n};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign cs_fall  = ~cs_q[1] & cs_q[2];
  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign cs_act   = ~cs_q[1];
  assign si_s     = si_q[1];
  assign wp_low   = ~wp_q[1];
endmodule

// File: rtl/spi_nvm_ram.sv
module spi_nvm_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_nvm_prot.sv
module spi_nvm_prot #(
  parameter int AW = 9
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb begin
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr[AW-1:AW-2];
      2'b10:   hit = addr[AW-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  import spi_nvm_pkg::*;

  localparam bit       A8_IN_OP   = (ADDR_W == 9);
  localparam int       ADDR_BYTES = A8_IN_OP ? 1 : (ADDR_W + 7) / 8;
  localparam int       ACC_W      = ADDR_BYTES * 8;
  localparam int       PG_W       = $clog2(PAGE_BYTES);
  localparam int       CNT_W      = $clog2(WRITE_CYCLES + 1);
  localparam logic [3:0] AB_CNT   = 4'(ADDR_BYTES);

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, si_s, wp_low;

  spi_nvm_sync sync_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_act(cs_act), .si_s(si_s), .wp_low(wp_low)
  );

  logic [6:0]        in_sh;
  logic [2:0]        bit_cnt;
  logic [3:0]        byte_cnt;
  cmd_e              cmd, op_cmd, op_gated;
  logic              a8;
  logic [ACC_W-1:0]  acc;
  logic [ADDR_W-1:0] ptr, full_addr;
  logic              addr_done, rd_req, rd_load;
  logic [7:0]        tx_sh;
  logic              tx_on;
  logic              sr_wpen, wel, busy;
  logic [1:0]        sr_wd, sr_bp;
  logic [4:0]        wrsr_val;
  logic              wp_seen;
  logic [7:0]        pb_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pb_vld;
  logic [PG_W-1:0]   cm_idx;
  logic              cm_active;
  logic [CNT_W-1:0]  busy_cnt;
  logic              ram_we, page_prot;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata, ram_rdata;

  wire        byte_end    = sck_rise && cs_act && (bit_cnt == 3'd7);
  wire [7:0]  rx_byte     = {in_sh, si_s};
  wire [7:0]  status_byte = {sr_wpen, 1'b0, sr_wd, sr_bp, wel, busy};
  wire        pb_we       = byte_end && (cmd == CMD_ARR_WR) && (byte_cnt > AB_CNT);

  generate
    if (A8_IN_OP) begin : g_a8
      assign full_addr = {a8, acc};
    end else begin : g_wide
      assign full_addr = acc[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    op_cmd   = decode_cmd(rx_byte, A8_IN_OP);
    op_gated = (busy && op_cmd != CMD_STAT_RD) ? CMD_NONE : op_cmd;
  end

  spi_nvm_prot #(.AW(ADDR_W)) prot_i (.bp(sr_bp), .addr(ptr), .hit(page_prot));

  assign ram_we    = cm_active && pb_vld[cm_idx];
  assign ram_addr  = cm_active ? {ptr[ADDR_W-1:PG_W], cm_idx} : ptr;
  assign ram_wdata = pb_mem[cm_idx];

  spi_nvm_ram #(.DW(8), .AW(ADDR_W)) ram_i (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  // page buffer storage, no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (pb_we) pb_mem[ptr[PG_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sh <= '0; bit_cnt <= '0; byte_cnt <= '0; cmd <= CMD_NONE; a8 <= 1'b0;
      acc <= '0; ptr <= '0; addr_done <= 1'b0; rd_req <= 1'b0; rd_load <= 1'b0;
      tx_sh <= '0; tx_on <= 1'b0; so <= 1'b0; so_en <= 1'b0;
      sr_wpen <= 1'b0; sr_wd <= '0; sr_bp <= '0; wel <= 1'b0; busy <= 1'b0;
      wrsr_val <= '0; wp_seen <= 1'b0; pb_vld <= '0;
      cm_idx <= '0; cm_active <= 1'b0; busy_cnt <= '0;
    end else begin
      addr_done <= 1'b0;
      rd_req    <= 1'b0;
      rd_load   <= rd_req;
      so_en     <= cs_act && tx_on;

      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        cmd      <= CMD_NONE;
        tx_on    <= 1'b0;
        wp_seen  <= wp_low;
        if (!busy) pb_vld <= '0;
      end else if (cs_act) begin
        wp_seen <= wp_seen | wp_low;
        if (sck_rise) begin
          in_sh   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt != 4'hF) byte_cnt <= byte_cnt + 4'd1;
            if (byte_cnt == 4'd0) begin
              cmd <= op_gated;
              a8  <= rx_byte[3];
              if (op_gated == CMD_STAT_RD) begin
                tx_sh <= status_byte;
                tx_on <= 1'b1;
              end
            end else begin
              case (cmd)
                CMD_STAT_RD: tx_sh <= status_byte;
                CMD_STAT_WR: if (byte_cnt == 4'd1) wrsr_val <= {rx_byte[7], rx_byte[5:2]};
                CMD_ARR_RD, CMD_ARR_WR: begin
                  if (byte_cnt <= AB_CNT) begin
                    acc <= ACC_W'({acc, rx_byte});
                    if (byte_cnt == AB_CNT) addr_done <= 1'b1;
                  end else if (cmd == CMD_ARR_RD) begin
                    rd_req <= 1'b1;
                  end else begin
                    pb_vld[ptr[PG_W-1:0]] <= 1'b1;
                    ptr <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + 1'b1};
                  end
                end
                default: ;
              endcase
            end
          end
        end
        if (sck_fall && tx_on) begin
          so    <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
        if (addr_done) begin
          ptr    <= full_addr;
          rd_req <= (cmd == CMD_ARR_RD);
        end
        if (rd_req) ptr <= ptr + ADDR_W'(1);
        if (rd_load) begin
          tx_sh <= ram_rdata;
          tx_on <= 1'b1;
        end
      end

      // self-timed cycle
      if (cm_active) begin
        cm_idx <= cm_idx + 1'b1;
        if (cm_idx == PG_W'(PAGE_BYTES - 1)) cm_active <= 1'b0;
      end
      if (busy) begin
        if (busy_cnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          busy_cnt <= busy_cnt - 1'b1;
        end
      end

      // commit point: end of a whole-byte transaction
      if (cs_rise) begin
        tx_on <= 1'b0;
        cmd   <= CMD_NONE;
        if (bit_cnt == 3'd0) begin
          case (cmd)
            CMD_WEN_SET: if (byte_cnt == 4'd1) wel <= 1'b1;
            CMD_WEN_CLR: if (byte_cnt == 4'd1) wel <= 1'b0;
            CMD_STAT_WR:
              if (wel && byte_cnt == 4'd2 && !(sr_wpen && wp_seen)) begin
                sr_wpen  <= wrsr_val[4];
                sr_wd    <= wrsr_val[3:2];
                sr_bp    <= wrsr_val[1:0];
                busy     <= 1'b1;
                busy_cnt <= CNT_W'(WRITE_CYCLES - 1);
              end
            CMD_ARR_WR:
              if (wel && byte_cnt > AB_CNT && !page_prot) begin
                busy      <= 1'b1;
                busy_cnt  <= CNT_W'(WRITE_CYCLES - 1);
                cm_active <= 1'b1;
                cm_idx    <= '0;
              end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvm_slave_chk.sv
module spi_nvm_slave_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              so_en,
  input logic              busy,
  input logic              wel,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [1:0]        bp
);
  function automatic logic in_region(input logic [1:0] f, input logic [ADDR_W-1:0] a);
    if (f == 2'b11) return 1'b1;
    if (f == 2'b10) return a >= ADDR_W'(1 << (ADDR_W - 1));
    if (f == 2'b01) return a >= ADDR_W'(3 << (ADDR_W - 2));
    return 1'b0;
  endfunction

  assert_so_off_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_en);

  assert_wel_clear_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  assert_cycle_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  assert_array_write_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  assert_no_protected_write_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !in_region(bp, ram_addr));

  assert_protect_steady_in_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bp));
endmodule

bind spi_nvm_slave spi_nvm_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cs_act(cs_act), .so_en(so_en), .busy(busy),
  .wel(wel), .ram_we(ram_we), .ram_addr(ram_addr), .bp(sr_bp)
);

// File: tb/spi_nvm_slave_tb_top.sv
module spi_nvm_slave_tb_top;
  localparam int H    = 6;
  localparam int WCYC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_en;

  int  checks = 0, errors = 0;
  bit  mode3 = 1'b0, done = 1'b0;
  logic [7:0] model [512];
  logic [7:0] wbuf  [16];
  logic [7:0] rbuf  [16];
  logic       en_any;

  always #10 clk = ~clk;

  spi_nvm_slave #(.ADDR_W(9), .PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_en(so_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      wclk(H);
      rx[i] = so;
      en_any = en_any | so_en;
      sck = 1'b1;
      wclk(H);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i]; wclk(H); sck = 1'b1; wclk(H);
    end
  endtask

  task automatic cs_on();
    sck = mode3; wclk(H); cs_n = 1'b0; en_any = 1'b0; wclk(H);
  endtask

  task automatic cs_off();
    if (!mode3) sck = 1'b0;
    wclk(H); cs_n = 1'b1; wclk(2 * H);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    cs_on(); xfer(op, d); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_on(); xfer(8'h05, d); xfer(8'h00, s); cs_off();
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] s;
    s = 8'h01;
    for (int k = 0; k < 200 && s[0]; k++) rdsr(s);
    chk(req, s[0], 0);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h01, d); xfer(v, d); cs_off();
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    logic [7:0] d;
    cs_on();
    xfer({4'h0, a[8], 3'b010}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    cs_off();
  endtask

  task automatic do_read(input logic [8:0] a, input int n);
    logic [7:0] d;
    cs_on();
    xfer({4'h0, a[8], 3'b011}, d);
    xfer(a[7:0], d);
    en_any = 1'b0;
    for (int i = 0; i < n; i++) begin xfer(8'h00, d); rbuf[i] = d; end
    cs_off();
  endtask

  task automatic model_write(input logic [8:0] a, input int n);
    for (int i = 0; i < n; i++) model[{a[8:4], 4'(a[3:0] + i)}] = wbuf[i];
  endtask

  task automatic check_read(input string req, input logic [8:0] a, input int n);
    do_read(a, n);
    for (int i = 0; i < n; i++) chk(req, rbuf[i], model[9'(a + i)]);
  endtask

  task automatic good_write(input logic [8:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) wbuf[i] = seed + 8'(i * 7);
    op1(8'h06); do_write(a, n); model_write(a, n); wait_ready("R7 cycle ends");
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 so_en after reset", so_en, 0);
    rdsr(s);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s, d, s2;
    op1(8'h06); rdsr(s); chk("R3 set latch", s, 8'h02);
    cs_on(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, s2); cs_off();
    chk("R2 repeated status byte", s2, 8'h02);
    chk("R12 so_en while shifting", en_any, 1);
    chk("R12 so_en after cs high", so_en, 0);
    cs_on(); xfer(8'h04, d); bits(8'h00, 3); cs_off();
    rdsr(s); chk("R11 partial byte discarded", s, 8'h02);
    op1(8'h04); rdsr(s); chk("R3 clear latch", s, 8'h00);
  endtask

  task automatic t_array();
    logic [7:0] s;
    good_write(9'h000, 1, 8'h3C);
    good_write(9'h1FF, 1, 8'hA5);
    good_write(9'h1C0, 1, 8'h5A);
    good_write(9'h1F0, 3, 8'h61);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i);
    op1(8'h06); do_write(9'h010, 4); model_write(9'h010, 4);
    rdsr(s); chk("R7 busy right after write", s[0], 1);
    wait_ready("R7 cycle ends");
    rdsr(s); chk("R7 latch cleared at end", s, 8'h00);
    check_read("R4 read back low page", 9'h010, 4);
    check_read("R4 read back with high address bit", 9'h1F0, 3);
    check_read("R4 read wraps at array end", 9'h1FF, 2);
  endtask

  task automatic t_page();
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    good_write(9'h02E, 4, 8'hC0);
    check_read("R5 page wrap start", 9'h020, 2);
    check_read("R5 page wrap end", 9'h02E, 2);
  endtask

  task automatic t_no_wel();
    logic [7:0] s;
    wbuf[0] = 8'hEE;
    do_write(9'h010, 1);
    rdsr(s); chk("R6 no cycle without latch", s, 8'h00);
    check_read("R6 array unchanged", 9'h010, 1);
    wrsr(8'h0C);
    rdsr(s); chk("R6 status write without latch", s, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    wbuf[0] = 8'h11;
    op1(8'h06); do_write(9'h050, 1); model_write(9'h050, 1);
    wbuf[0] = 8'h99;
    do_write(9'h050, 1);
    do_read(9'h010, 2);
    chk("R7 read ignored while busy", en_any, 0);
    rdsr(s); chk("R7 still busy", s[0], 1);
    wait_ready("R7 cycle ends");
    check_read("R7 write ignored while busy", 9'h050, 1);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    op1(8'h06); wrsr(8'h04); wait_ready("R7 cycle ends");
    rdsr(s); chk("R8 protect field set", s, 8'h04);
    wbuf[0] = 8'h77;
    op1(8'h06); do_write(9'h1C0, 1);
    rdsr(s); chk("R8 quarter write refused", s, 8'h06);
    check_read("R8 top quarter unchanged", 9'h1C0, 1);
    op1(8'h04);
    good_write(9'h170, 1, 8'h42);
    check_read("R8 below quarter written", 9'h170, 1);
    op1(8'h06); wrsr(8'h08); wait_ready("R7 cycle ends");
    wbuf[0] = 8'h01; op1(8'h06); do_write(9'h100, 1);
    rdsr(s); chk("R8 half write refused", s, 8'h0A);
    op1(8'h04);
    op1(8'h06); wrsr(8'h0C); wait_ready("R7 cycle ends");
    wbuf[0] = 8'h02; op1(8'h06); do_write(9'h000, 1);
    rdsr(s); chk("R8 whole-array write refused", s, 8'h0E);
    check_read("R8 address 0 unchanged", 9'h000, 1);
    wrsr(8'h00); wait_ready("R7 cycle ends");
  endtask

  task automatic t_wp();
    logic [7:0] s, d;
    op1(8'h06); wrsr(8'h80);
    wp_n = 1'b0;
    wait_ready("R7 cycle ends");
    rdsr(s); chk("R10 pin low during cycle", s, 8'h80);
    op1(8'h06); wrsr(8'h0C);
    rdsr(s); chk("R9 locked status write", s, 8'h82);
    wp_n = 1'b1;
    cs_on(); xfer(8'h01, d); wp_n = 1'b0; wclk(4); wp_n = 1'b1; xfer(8'h04, d); cs_off();
    rdsr(s); chk("R9 pin pulse cancels write", s, 8'h82);
    wrsr(8'h00); wait_ready("R7 cycle ends");
    rdsr(s); chk("R9 unlock with pin high", s, 8'h00);
    wp_n = 1'b0;
    op1(8'h06); wrsr(8'h20); wait_ready("R7 cycle ends");
    rdsr(s); chk("R9 pin ignored when unlocked", s, 8'h20);
    op1(8'h06); wrsr(8'h00); wait_ready("R7 cycle ends");
    wp_n = 1'b1;
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    mode3 = 1'b1;
    op1(8'h06); rdsr(s); chk("R13 status in mode 3", s, 8'h02);
    good_write(9'h0A3, 2, 8'h90);
    check_read("R13 read in mode 3", 9'h0A3, 2);
    mode3 = 1'b0;
    sck = 1'b0; wclk(2 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    rst = 1'b1; wclk(5); rst = 1'b0; wclk(4);
    t_reset();
    t_latch();
    t_array();
    t_page();
    t_no_wel();
    t_busy();
    t_protect();
    t_wp();
    t_mode3();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule